// File: doc/BRIEF.md
# Converter Timing Source Selector with Prescaler

This block decides where a data converter takes its sampling timing from and delivers that timing as a clock enable, never as a derived clock. A 2-bit mode field picks between two schemes. In the first, an independent kernel clock that runs asynchronously to the bus clock drives a prescaler. Its ratio comes from an 11-entry set that includes the non-power-of-two values 6 and 12. In the second, the bus clock itself is divided by 1, 2 or 4, so everything stays in one clock domain.

The block also carries an external start trigger toward the converter timing. On the kernel path the trigger passes through a two-flop synchronizer and an edge detector, which costs a few kernel cycles and leaves an uncertainty of up to one cycle in the trigger instant. On the bus path the trigger edge is decoded in the same cycle it arrives, with no resynchronization, so its timing is exact. Each domain has its own enable output and its own trigger output. Only the outputs that belong to the selected scheme are active. The mode and ratio fields are quasi-static configuration: they change only while the converter is idle.

Top module: `adc_ck_sel`

## Requirements
- R1: With mode 00, `k_en_o` pulses on the kernel clock and `b_en_o` stays low.
- R2: With mode 01, 10 or 11, `b_en_o` pulses every 1, 2 or 4 bus cycles respectively, and `k_en_o` stays low.
- R3: The prescaler index `pres_i` values 0 to 10 select the ratios 1, 2, 4, 6, 8, 12, 16, 32, 64, 128 and 256, in that order. In steady state `k_en_o` is high for one kernel cycle in every `ratio` kernel cycles.
- R4: Any prescaler index from 11 to 31 behaves as ratio 1.
- R5: After `pres_i` changes, the kernel counter restarts. No pulse appears on the kernel edge that first sees the new value. The first pulse is present after the (ratio+1)-th kernel edge counted from that edge, even if the change lands on the cycle where a pulse was due.
- R6: After `mode_i` changes, the counter of the newly selected domain restarts and that domain emits no enable on its first edge. The first pulse is present after the (divide+1)-th edge of that domain.
- R7: In a bus mode, `b_trig_o` goes high in the same bus cycle in which `trig_i` rises, with no register delay, and falls after the next bus edge. In mode 00 it stays low.
- R8: In mode 00, a rising edge on `trig_i` produces exactly one kernel cycle of `k_trig_o`, present after the third kernel edge following the rise. In a bus mode `k_trig_o` stays low.
- R9: While a domain's reset is low, its enable and trigger outputs are low. After reset, that domain emits no trigger pulse until its first enable has been emitted.
- R10: With mode 01 held for two bus edges in a row, `b_en_o` is high on every bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | Independent kernel clock |
| k_rst_n | input | 1 | Active-low reset, kernel domain |
| b_clk | input | 1 | Bus clock |
| b_rst_n | input | 1 | Active-low reset, bus domain |
| mode_i | input | 2 | Timing source: 00 kernel, 01 bus/1, 10 bus/2, 11 bus/4 |
| pres_i | input | 5 | Kernel prescaler index (0..10, above 10 = ratio 1) |
| trig_i | input | 1 | External conversion trigger |
| k_en_o | output | 1 | Sampling enable, kernel domain |
| b_en_o | output | 1 | Sampling enable, bus domain |
| k_trig_o | output | 1 | Resynchronized trigger pulse, kernel domain |
| b_trig_o | output | 1 | Direct trigger pulse, bus domain |

## Verification
Two events can fall on the same edge: a ratio or mode change, and the terminal count of the counter that is running. When both happen at once, the restart must win. The bench waits for a kernel pulse, counts ratio-1 edges, and then changes the index so that the restart is seen on the edge that would have set the next pulse. It then checks that no pulse appears there and that the first pulse comes exactly new-ratio+1 edges later. Mode switches are checked the same way, with the first-pulse distance measured in the domain being entered.

// File: rtl/adc_ck_pkg.sv
package adc_ck_pkg;

   localparam int unsigned PRES_STEPS = 11;

   // Ratio selected by a prescaler index; indices past the table fall to 1.
   function automatic int unsigned pres_ratio(input int unsigned idx);
      int unsigned r;
      case (idx)
         0:       r = 1;
         1:       r = 2;
         2:       r = 4;
         3:       r = 6;
         4:       r = 8;
         5:       r = 12;
         6:       r = 16;
         7:       r = 32;
         8:       r = 64;
         9:       r = 128;
         10:      r = 256;
         default: r = 1;
      endcase
      return r;
   endfunction

   // Bus-clock divide factor for a mode code (00 has no bus divide).
   function automatic int unsigned bus_div(input int unsigned code);
      int unsigned d;
      case (code)
         1:       d = 1;
         2:       d = 2;
         3:       d = 4;
         default: d = 1;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/ck_en_div.sv
module ck_en_div #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          active,
   input  logic [CW-1:0] limit,
   output logic          en
);

   logic [CW-1:0] cnt_q;
   logic          term;

   assign term = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en    <= 1'b0;
      end else if (restart || !active) begin
         cnt_q <= '0;
         en    <= 1'b0;
      end else begin
         en    <= term;
         cnt_q <= term ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/trig_path.sv
module trig_path #(
   parameter bit RESYNC = 1'b1,
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic allow,
   output logic pulse_o
);

   generate
      if (RESYNC) begin : g_sync
         logic [STAGES-1:0] sync_q;
         logic              prev_q;
         logic              pulse_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q  <= '0;
               prev_q  <= 1'b0;
               pulse_q <= 1'b0;
            end else begin
               sync_q  <= {sync_q[STAGES-2:0], trig_i};
               prev_q  <= sync_q[STAGES-1];
               pulse_q <= allow & sync_q[STAGES-1] & ~prev_q;
            end
         end
         assign pulse_o = pulse_q;
      end else begin : g_direct
         logic prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= trig_i;
         end
         assign pulse_o = allow & trig_i & ~prev_q;
      end
   endgenerate

endmodule

// File: rtl/adc_ck_sel.sv
module adc_ck_sel #(
   parameter int MODE_W      = 2,
   parameter int PRES_W      = 5,
   parameter int MAX_RATIO   = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic              k_clk,
   input  logic              k_rst_n,
   input  logic              b_clk,
   input  logic              b_rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [PRES_W-1:0] pres_i,
   input  logic              trig_i,
   output logic              k_en_o,
   output logic              b_en_o,
   output logic              k_trig_o,
   output logic              b_trig_o
);
   import adc_ck_pkg::*;

   localparam int KCW = $clog2(MAX_RATIO);
   localparam int BCW = 2;

   generate
      if (MODE_W != 2) begin : g_bad_mode
         $error("MODE_W must be 2");
      end
      if (PRES_W < 4) begin : g_bad_pres
         $error("PRES_W must hold indices up to 10");
      end
      if (MAX_RATIO < 256) begin : g_bad_ratio
         $error("MAX_RATIO must cover the largest prescaler ratio");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- kernel domain ----------------
   logic [MODE_W-1:0] k_mode_q;
   logic [PRES_W-1:0] k_pres_q;
   logic              k_live_q;
   logic              k_active;
   logic              k_restart;
   logic [KCW-1:0]    k_limit;

   assign k_active  = (mode_i == '0);
   assign k_restart = (mode_i != k_mode_q) || (pres_i != k_pres_q);
   assign k_limit   = KCW'(pres_ratio(int'(pres_i)) - 1);

   always_ff @(posedge k_clk or negedge k_rst_n) begin
      if (!k_rst_n) begin
         k_mode_q <= '0;
         k_pres_q <= '0;
         k_live_q <= 1'b0;
      end else begin
         k_mode_q <= mode_i;
         k_pres_q <= pres_i;
         k_live_q <= k_live_q | k_en_o;
      end
   end

   ck_en_div #(.CW(KCW)) u_kdiv (
      .clk     (k_clk),
      .rst_n   (k_rst_n),
      .restart (k_restart),
      .active  (k_active),
      .limit   (k_limit),
      .en      (k_en_o)
   );

   trig_path #(.RESYNC(1'b1), .STAGES(SYNC_STAGES)) u_ktrig (
      .clk     (k_clk),
      .rst_n   (k_rst_n),
      .trig_i  (trig_i),
      .allow   (k_active & k_live_q),
      .pulse_o (k_trig_o)
   );

   // ---------------- bus domain ----------------
   logic [MODE_W-1:0] b_mode_q;
   logic              b_live_q;
   logic              b_active;
   logic              b_restart;
   logic [BCW-1:0]    b_limit;

   assign b_active  = (mode_i != '0);
   assign b_restart = (mode_i != b_mode_q);
   assign b_limit   = BCW'(bus_div(int'(mode_i)) - 1);

   always_ff @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n) begin
         b_mode_q <= '0;
         b_live_q <= 1'b0;
      end else begin
         b_mode_q <= mode_i;
         b_live_q <= b_live_q | b_en_o;
      end
   end

   ck_en_div #(.CW(BCW)) u_bdiv (
      .clk     (b_clk),
      .rst_n   (b_rst_n),
      .restart (b_restart),
      .active  (b_active),
      .limit   (b_limit),
      .en      (b_en_o)
   );

   trig_path #(.RESYNC(1'b0), .STAGES(SYNC_STAGES)) u_btrig (
      .clk     (b_clk),
      .rst_n   (b_rst_n),
      .trig_i  (trig_i),
      .allow   (b_active & b_live_q),
      .pulse_o (b_trig_o)
   );

endmodule

// File: rtl/adc_ck_sel_chk.sv
module adc_ck_sel_chk (
   input logic       k_clk,
   input logic       k_rst_n,
   input logic       b_clk,
   input logic       b_rst_n,
   input logic [1:0] mode_i,
   input logic [4:0] pres_i,
   input logic       trig_i,
   input logic       k_en_o,
   input logic       b_en_o,
   input logic       k_trig_o,
   input logic       b_trig_o
);

   // R1: a kernel enable only follows a kernel-mode sample
   p_kern_only_r1: assert property (@(posedge k_clk) disable iff (!k_rst_n)
      k_en_o |-> ($past(mode_i) == 2'b00));

   // R2: a bus enable only follows a bus-mode sample
   p_bus_only_r2: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      b_en_o |-> ($past(mode_i) != 2'b00));

   // R6: a bus-side mode change blanks the next enable
   p_mode_gap_r6: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (mode_i != $past(mode_i)) |=> !b_en_o);

   // R7: the direct trigger never fires in kernel mode
   p_btrig_mode_r7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      b_trig_o |-> (mode_i != 2'b00));

   // R8: the resynchronized trigger lasts a single kernel cycle
   p_ktrig_single_r8: assert property (@(posedge k_clk) disable iff (!k_rst_n)
      k_trig_o |=> !k_trig_o);

   // R10: divide-by-one keeps the enable high
   p_div1_full_r10: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      ($past(b_rst_n, 2) && $past(mode_i, 2) == 2'b01 && $past(mode_i) == 2'b01)
      |-> b_en_o);

endmodule

bind adc_ck_sel adc_ck_sel_chk u_chk (.*);

// File: tb/sim_adc_ck_sel.sv
module sim_adc_ck_sel;

   logic       k_clk = 1'b0;
   logic       b_clk = 1'b0;
   logic       k_rst_n = 1'b0;
   logic       b_rst_n = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic [4:0] pres_i = 5'd10;
   logic       trig_i = 1'b0;
   logic       k_en_o, b_en_o, k_trig_o, b_trig_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 b_clk = ~b_clk;
   always #7 k_clk = ~k_clk;

   adc_ck_sel u0 (
      .k_clk, .k_rst_n, .b_clk, .b_rst_n, .mode_i, .pres_i, .trig_i,
      .k_en_o, .b_en_o, .k_trig_o, .b_trig_o
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ratio_ref(input int idx);
      int tbl[11] = '{1, 2, 4, 6, 8, 12, 16, 32, 64, 128, 256};
      return (idx <= 10) ? tbl[idx] : 1;
   endfunction

   // Count kernel edges until k_en_o is seen high.
   task automatic k_wait(output int n);
      n = 0;
      do begin
         @(posedge k_clk); n++; @(negedge k_clk);
      end while (!k_en_o && n < 600);
   endtask

   task automatic b_wait(output int n);
      n = 0;
      do begin
         @(posedge b_clk); n++; @(negedge b_clk);
      end while (!b_en_o && n < 20);
   endtask

   // R3/R4/R5: change index, check first-pulse distance and steady period
   task automatic t_kratio(input int idx);
      int n;
      int r = ratio_ref(idx);
      @(negedge k_clk) pres_i = 5'(idx);
      k_wait(n);
      chk(n == r + 1, $sformatf("R5 reload idx=%0d", idx), n, r + 1);
      k_wait(n);
      chk(n == r, (idx > 10) ? $sformatf("R4 idx=%0d", idx)
                             : $sformatf("R3 idx=%0d", idx), n, r);
      chk(b_en_o == 1'b0, "R1 bus enable low", b_en_o, 0);
   endtask

   // R5: change lands on the edge where a pulse was due
   task automatic t_collide;
      int n;
      @(negedge k_clk) pres_i = 5'd2;           // ratio 4
      k_wait(n);
      repeat (3) @(negedge k_clk);
      pres_i = 5'd1;                            // ratio 2
      k_wait(n);
      chk(n == 3, "R5 collide restart", n, 3);
   endtask

   // R2/R6: enter a bus mode and time the enables
   task automatic t_bmode(input int m);
      int n;
      int d = (m == 1) ? 1 : (m == 2) ? 2 : 4;
      @(negedge b_clk) mode_i = 2'(m);
      b_wait(n);
      chk(n == d + 1, $sformatf("R6 bus mode=%0d first", m), n, d + 1);
      b_wait(n);
      chk(n == d, $sformatf("R2 bus mode=%0d period", m), n, d);
      repeat (4) @(negedge b_clk);
      for (int i = 0; i < 8; i++) begin
         @(negedge b_clk);
         chk(k_en_o == 1'b0, "R2 kernel enable low", k_en_o, 0);
         if (m == 1) chk(b_en_o == 1'b1, "R10 div1 every cycle", b_en_o, 1);
      end
   endtask

   // R6: enter kernel mode from a bus mode
   task automatic t_kenter;
      int n;
      @(negedge k_clk) mode_i = 2'b00;
      k_wait(n);
      chk(n == ratio_ref(int'(pres_i)) + 1, "R6 kernel mode first", n,
          ratio_ref(int'(pres_i)) + 1);
      repeat (3) @(negedge b_clk);
      chk(b_en_o == 1'b0, "R1 bus enable low after switch", b_en_o, 0);
   endtask

   // R8 (and R7 gating in kernel mode)
   task automatic t_ktrig;
      @(negedge k_clk) trig_i = 1'b1;
      #1 chk(b_trig_o == 1'b0, "R7 no bus trigger in mode 00", b_trig_o, 0);
      for (int i = 1; i <= 4; i++) begin
         @(posedge k_clk); @(negedge k_clk);
         chk(k_trig_o == (i == 3), $sformatf("R8 kernel trigger edge %0d", i),
             k_trig_o, (i == 3));
      end
      trig_i = 1'b0;
      repeat (4) @(negedge k_clk);
   endtask

   // R7 (and R8 gating in bus mode)
   task automatic t_btrig;
      @(negedge b_clk) trig_i = 1'b1;
      #1 chk(b_trig_o == 1'b1, "R7 direct trigger same cycle", b_trig_o, 1);
      @(posedge b_clk); #1;
      chk(b_trig_o == 1'b0, "R7 direct trigger one cycle", b_trig_o, 0);
      for (int i = 0; i < 6; i++) begin
         @(negedge k_clk);
         chk(k_trig_o == 1'b0, "R8 no kernel trigger in bus mode", k_trig_o, 0);
      end
      trig_i = 1'b0;
      repeat (3) @(negedge b_clk);
   endtask

   // R9: reset state and no trigger before first enable
   task automatic t_reset;
      repeat (3) @(negedge k_clk);
      chk({k_en_o, b_en_o, k_trig_o, b_trig_o} == 4'b0, "R9 outputs in reset",
          {k_en_o, b_en_o, k_trig_o, b_trig_o}, 0);
      @(negedge k_clk) begin k_rst_n = 1'b1; b_rst_n = 1'b1; end
      repeat (20) @(negedge k_clk);
      trig_i = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge k_clk);
         chk(k_trig_o == 1'b0, "R9 no trigger before first enable", k_trig_o, 0);
      end
      trig_i = 1'b0;
      chk(k_en_o == 1'b0, "R9 no early enable", k_en_o, 0);
      while (!k_en_o) @(negedge k_clk);
      repeat (2) @(negedge k_clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset;
      t_ktrig;
      for (int i = 0; i <= 10; i++) t_kratio(i);
      t_kratio(13);
      t_kratio(31);
      t_collide;
      t_bmode(1);
      t_bmode(2);
      t_bmode(3);
      t_bmode(2);
      t_btrig;
      @(negedge b_clk) pres_i = 5'd3;
      t_kenter;
      t_ktrig;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule